// File: doc/BRIEF.md
# Serial Shift Register with Parallel Storage

This block pairs a shift register with a storage register of the same width, 16 bits by default. Both are linked in each direction. A single serial port moves data in and out of the shift register. The port is modelled as three signals: a serial data input, a serial data output and an output enable. When the port faces inward, a shift moves the incoming bit into bit 0. When read mode is selected, the port drives the top bit outward, and a shift rotates that bit back into bit 0. This means a read leaves the word intact after a full turn.

The storage register drives the parallel output bus. On a store command it captures the shift register. On a load command the shift register takes the storage word back. An active-low store-clear input empties the storage register at once, with no clock. An active-low chip select gates every clocked action and the serial output enable. Store clear is the one function that chip select does not gate. The two clocks of a discrete part are modelled here as enables on one system clock. A synchronous active-low reset clears only the shift register.

Top module: `serial_store_shifter`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the shift register becomes all zeros at that edge. The storage register and `par_out` are unchanged by `rst_n`.
- R2: While `clr_n` is low, the storage register and `par_out` are zero without waiting for a clock edge, whatever the value of `cs_n`.
- R3: With `cs_n` low and `store_en` high at a rising edge, the storage register takes the shift register's pre-edge value, and `par_out` shows it after that edge.
- R4: With `cs_n` low and `load_en` high at a rising edge, the shift register takes the storage register's pre-edge value.
- R5: With `cs_n` low, `shift_en` high, `load_en` low and `read_mode` low, an edge moves every bit up one place. Bit 0 takes `ser_in`, and the old bit 15 (the MSB) is discarded.
- R6: With `cs_n` low and `read_mode` high, `ser_oe` is 1 and `ser_out` equals the shift register's MSB. A shift in this mode moves the MSB into bit 0, so after 16 shifts the word is back where it started.
- R7: With `cs_n` high, no shift, load or store takes place, whatever the command inputs are, and `ser_oe` is 0.
- R8: When `load_en` and `shift_en` are both high in the same enabled cycle, the parallel load takes effect and the shift is dropped.
- R9: When `store_en` and `load_en` are both high in the same enabled cycle, the two registers exchange their pre-edge contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every synchronous action happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the shift register |
| clr_n | input | 1 | Asynchronous active-low clear of the storage register |
| cs_n | input | 1 | Active-low chip select that gates all clocked actions and the serial output |
| shift_en | input | 1 | Shift request |
| load_en | input | 1 | Copy storage register into shift register |
| store_en | input | 1 | Copy shift register into storage register |
| read_mode | input | 1 | 1: port drives MSB out and shifts recirculate; 0: port is an input |
| ser_in | input | 1 | Serial data entering bit 0 |
| ser_out | output | 1 | Shift register MSB |
| ser_oe | output | 1 | Serial port drive enable |
| par_out | output | WIDTH | Storage register contents |

## Verification
The bench goes after the command collisions. If load and shift arrive together, a design that shifts instead leaves a word offset by one bit. If load and store arrive together, a design that sequences them loses one of the two words instead of exchanging them. A full read of 16 rotations must return the written word and present each bit on `ser_out` in MSB-first order. A design that shifts zeros in, or reads the wrong end, breaks the stored pattern. Storage is also checked with chip select high while every command is asserted, across a reset, and against a store clear pulsed in mid-cycle. A design that gates the clear with chip select, or ties storage to `rst_n`, shows a wrong `par_out`.

// File: rtl/ssr_pkg.sv
// Shared definitions for the serial shift register with storage.
// Assumes: one system clock; all register actions are enables on it.
package ssr_pkg;

    // Next action of the shift register for the coming edge.
    typedef enum logic [1:0] {
        OP_HOLD     = 2'd0,
        OP_LOAD     = 2'd1,
        OP_SHIFT_IN = 2'd2,
        OP_ROTATE   = 2'd3
    } shift_op_e;

endpackage

// File: rtl/ssr_ctrl.sv
// Command decoder: turns chip select and the command inputs into one
// shift-register operation, a store strobe and the serial drive enable.
// Assumes: load outranks shift; store is independent of the shift op.
module ssr_ctrl
    import ssr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      shift_en,
    input  logic      load_en,
    input  logic      store_en,
    input  logic      read_mode,
    output shift_op_e op,
    output logic      store_go,
    output logic      ser_oe
);

    // Pick the shift-register operation with load first, then shift.
    always_comb begin
        if (cs_n)
            op = OP_HOLD;
        else if (load_en)
            op = OP_LOAD;
        else if (shift_en)
            op = read_mode ? OP_ROTATE : OP_SHIFT_IN;
        else
            op = OP_HOLD;
    end

    // Store strobe and port direction, both gated by chip select.
    always_comb begin
        store_go = !cs_n && store_en;
        ser_oe   = !cs_n && read_mode;
    end

    // R7
    cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (op == OP_HOLD && !store_go && !ser_oe));

    // R8
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && load_en && shift_en) |-> (op == OP_LOAD));

endmodule

// File: rtl/ssr_shift_core.sv
// Shift register: parallel load, shift-in at bit 0, or rotate MSB to bit 0.
// Assumes: op already carries chip-select gating and priority.
module ssr_shift_core
    import ssr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  shift_op_e        op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] sreg_q
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sreg_d;

    // Next-state select for the shift register.
    always_comb begin
        case (op)
            OP_LOAD:     sreg_d = par_in;
            OP_SHIFT_IN: sreg_d = {sreg_q[MSB-1:0], ser_in};
            OP_ROTATE:   sreg_d = {sreg_q[MSB-1:0], sreg_q[MSB]};
            default:     sreg_d = sreg_q;
        endcase
    end

    // Register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg_q <= '0;
        else
            sreg_q <= sreg_d;
    end

    // R1
    sreg_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (sreg_q == '0));

    // R4
    sreg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (sreg_q == $past(par_in)));

    // R5
    sreg_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT_IN) |=> (sreg_q[0] == $past(ser_in)
                                 && sreg_q[MSB:1] == $past(sreg_q[MSB-1:0])));

    // R6
    sreg_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ROTATE) |=> (sreg_q[0] == $past(sreg_q[MSB])));

    // R7
    sreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(sreg_q));

endmodule

// File: rtl/ssr_store_reg.sv
// Storage register: captures the shift register on a store strobe,
// cleared asynchronously by an active-low clear that nothing gates.
// Assumes: the system reset does not touch this register.
module ssr_store_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             store_go,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Capture on strobe, clear at once while clr_n is low.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else if (store_go)
            q <= d;
    end

    // R2
    store_clear_chk: assert property (@(posedge clk)
        !clr_n |-> (q == '0));

    // R3
    store_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
        store_go |=> (q == $past(d)));

    // R7
    store_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !store_go |=> $stable(q));

endmodule

// File: rtl/serial_store_shifter.sv
// Top level: shift register and storage register joined both ways, with
// one serial port shown as data-in, data-out and drive enable.
// Assumes: pad tristate buffers sit outside this block.
module serial_store_shifter
    import ssr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             cs_n,
    input  logic             shift_en,
    input  logic             load_en,
    input  logic             store_en,
    input  logic             read_mode,
    input  logic             ser_in,
    output logic             ser_out,
    output logic             ser_oe,
    output logic [WIDTH-1:0] par_out
);

    localparam int MSB = WIDTH - 1;

    shift_op_e        op;
    logic             store_go;
    logic [WIDTH-1:0] sreg_q;
    logic [WIDTH-1:0] store_q;

    ssr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .shift_en  (shift_en),
        .load_en   (load_en),
        .store_en  (store_en),
        .read_mode (read_mode),
        .op        (op),
        .store_go  (store_go),
        .ser_oe    (ser_oe)
    );

    ssr_shift_core #(.WIDTH(WIDTH)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .ser_in (ser_in),
        .par_in (store_q),
        .sreg_q (sreg_q)
    );

    ssr_store_reg #(.WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .clr_n    (clr_n),
        .store_go (store_go),
        .d        (sreg_q),
        .q        (store_q)
    );

    // Port outputs: serial MSB and the parallel storage word.
    always_comb begin
        ser_out = sreg_q[MSB];
        par_out = store_q;
    end

    // R9
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (op == OP_LOAD && store_go) |=>
            (sreg_q == $past(store_q) && store_q == $past(sreg_q)));

endmodule

// File: tb/tb_serial_store_shifter.sv
module tb_serial_store_shifter;

    localparam int CLK_P = 10;
    localparam int W     = 16;

    typedef struct {
        logic [W-1:0] par;
        logic         oe;
        logic         so;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         shift_en = 1'b0;
    logic         load_en = 1'b0;
    logic         store_en = 1'b0;
    logic         read_mode = 1'b0;
    logic         ser_in = 1'b0;
    logic         ser_out;
    logic         ser_oe;
    logic [W-1:0] par_out;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];

    logic [W-1:0] m_sr = '0;
    logic [W-1:0] m_st = '0;

    serial_store_shifter #(.WIDTH(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .cs_n      (cs_n),
        .shift_en  (shift_en),
        .load_en   (load_en),
        .store_en  (store_en),
        .read_mode (read_mode),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .ser_oe    (ser_oe),
        .par_out   (par_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one clock cycle of stimulus, model update, expected push.
    task automatic cyc(input bit cs, input bit sh, input bit rd, input bit ld,
                       input bit st, input bit si, input bit rs, input string tag);
        logic [W-1:0] nsr;
        logic [W-1:0] nst;
        exp_t e;
        @(negedge clk);
        cs_n = cs; shift_en = sh; read_mode = rd; load_en = ld;
        store_en = st; ser_in = si; rst_n = rs;
        @(posedge clk);
        if (!rs)             nsr = '0;
        else if (!cs && ld)  nsr = m_st;
        else if (!cs && sh)  nsr = {m_sr[W-2:0], rd ? m_sr[W-1] : si};
        else                 nsr = m_sr;
        if (!clr_n)          nst = '0;
        else if (!cs && st)  nst = m_sr;
        else                 nst = m_st;
        m_sr = nsr;
        m_st = nst;
        e.par = m_st; e.oe = !cs && rd; e.so = m_sr[W-1]; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare each expected item a quarter period after its edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(par_out === e.par, {e.tag, " par_out"}, par_out, e.par);
                chk(ser_oe === e.oe, {e.tag, " ser_oe"}, W'(ser_oe), W'(e.oe));
                if (e.oe)
                    chk(ser_out === e.so, {e.tag, " ser_out"}, W'(ser_out), W'(e.so));
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [W-1:0] PAT_A = 16'hA5C3;
    localparam logic [W-1:0] PAT_B = 16'h3C96;

    initial begin
        // R1 R2 reset state: shift reg cleared, storage cleared by clr_n
        cyc(1, 0, 0, 0, 0, 0, 0, "R1 reset");
        cyc(1, 0, 0, 0, 0, 0, 0, "R2 clear");
        clr_n = 1'b1;

        // R5 write PAT_A serially, MSB first
        for (int i = W - 1; i >= 0; i--)
            cyc(0, 1, 0, 0, 0, PAT_A[i], 1, "R5 shift-in");
        // R3 store with read mode shows MSB on the port (R6)
        cyc(0, 0, 1, 0, 1, 0, 1, "R3 store");

        // R6 full rotation read, ser_out checked each cycle
        for (int i = 0; i < W; i++)
            cyc(0, 1, 1, 0, 0, 0, 1, "R6 rotate");
        cyc(0, 0, 0, 0, 1, 0, 1, "R6 word intact");

        // R7 chip select high blocks every command
        for (int i = 0; i < 4; i++)
            cyc(0, 1, 0, 0, 0, 1, 1, "R5 ones");
        for (int i = 0; i < 3; i++)
            cyc(1, 1, 0, 1, 1, 0, 1, "R7 deselected");
        cyc(0, 0, 0, 0, 1, 0, 1, "R7 store after");

        // R4 load: write PAT_B, store, overwrite, load, read back
        for (int i = W - 1; i >= 0; i--)
            cyc(0, 1, 0, 0, 0, PAT_B[i], 1, "R5 shift-in B");
        cyc(0, 0, 0, 0, 1, 0, 1, "R3 store B");
        for (int i = 0; i < 8; i++)
            cyc(0, 1, 0, 0, 0, i[0], 1, "R5 scramble");
        cyc(0, 0, 0, 1, 0, 0, 1, "R4 load");
        for (int i = 0; i < W; i++)
            cyc(0, 1, 1, 0, 0, 0, 1, "R4 readback");

        // R8 load beats shift
        for (int i = 0; i < 5; i++)
            cyc(0, 1, 0, 0, 0, 1, 1, "R5 prep");
        cyc(0, 1, 0, 1, 0, 1, 1, "R8 load+shift");
        for (int i = 0; i < W; i++)
            cyc(0, 1, 1, 0, 0, 0, 1, "R8 readback");

        // R9 store and load together exchange contents
        for (int i = 0; i < 6; i++)
            cyc(0, 1, 0, 0, 0, 0, 1, "R5 prep2");
        cyc(0, 0, 0, 1, 1, 0, 1, "R9 swap");
        for (int i = 0; i < W; i++)
            cyc(0, 1, 1, 0, 0, 0, 1, "R9 readback");

        // R1 reset leaves storage, then store shows zeroed shift reg
        cyc(0, 0, 0, 0, 0, 0, 0, "R1 storage kept");
        cyc(0, 0, 0, 0, 1, 0, 1, "R1 shift cleared");

        // R2 asynchronous clear with chip select high, mid-cycle
        for (int i = W - 1; i >= 0; i--)
            cyc(0, 1, 0, 0, 0, PAT_A[i], 1, "R5 refill");
        cyc(0, 0, 0, 0, 1, 0, 1, "R3 store refill");
        @(negedge clk);
        cs_n = 1'b1;
        #(CLK_P/4);
        clr_n = 1'b0;
        #1;
        chk(par_out === '0, "R2 async clear", par_out, '0);
        cyc(1, 0, 0, 0, 0, 0, 1, "R2 held clear");
        @(negedge clk);
        clr_n = 1'b1;
        cyc(0, 0, 0, 0, 1, 0, 1, "R2 shift kept");

        @(posedge clk);
        #(CLK_P/2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule